// File: doc/BRIEF.md
# Four-Lane Vector Arithmetic Unit

This block is the arithmetic core of a programmable vertex processor. Every cycle it can take one instruction: a 4-bit opcode and three source vectors of four lanes each. The sources arrive already swizzled and negated, and write masking happens downstream. After a fixed three-cycle latency, which is the same for every opcode, the unit returns a four-lane result together with a valid flag that has travelled down the pipeline with the instruction.

Each lane holds a signed Q16.16 fixed-point value: 16 integer bits and 16 fraction bits in two's complement. The unit supports these operations:

- component-wise move, add, multiply and multiply-add;
- signed minimum and maximum;
- the two set-on-compare operations;
- dot products over three or four lanes.

A dot product writes its scalar result into all four output lanes, so the write mask further on can send it to any destination component. Component-wise operations and dot products share one pipeline and have the same timing.

Top module: `vau_core`

## Requirements
- R1: An instruction sampled with `in_valid` high at a rising edge appears with `out_valid` high exactly three rising edges later. A new instruction may be accepted every cycle, and `out_valid` follows the `in_valid` pattern delayed by three cycles.
- R2: Lane i is bits [32i+31:32i], with lane 0 as x and lane 3 as w. Opcode 0 (move) returns A. Opcode 2 (add) returns A+B per lane, wrapping modulo 2^32.
- R3: Opcode 1 (multiply) returns, per lane, the full 64-bit signed product of A and B, arithmetically shifted right by 16 and truncated to its low 32 bits.
- R4: Opcode 3 (multiply-add) returns, per lane, the R3 product of A and B plus C, wrapping modulo 2^32.
- R5: Opcode 4 (3-lane dot product) sums the R3 products of lanes 0, 1 and 2 with wrap, ignores lane 3, and writes the sum to all four lanes.
- R6: Opcode 5 (4-lane dot product) sums the R3 products of all four lanes with wrap and writes the sum to all four lanes.
- R7: Opcodes 6 and 7 return, per lane, the signed minimum and the signed maximum of A and B.
- R8: Opcode 8 writes 0x00010000 (1.0) to a lane when A < B (signed), otherwise 0. Opcode 9 writes 0x00010000 when A >= B, otherwise 0.
- R9: Opcodes 10 to 15 produce an all-zero result.
- R10: While `rst_n` is low at a rising edge, the pipeline is flushed: `out_valid` is 0 and `out_res` is 0. No instruction that was presented during reset ever emerges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 4 | Opcode |
| in_a | input | 128 | Source A, four Q16.16 lanes |
| in_b | input | 128 | Source B, four Q16.16 lanes |
| in_c | input | 128 | Source C (multiply-add addend) |
| out_valid | output | 1 | Result valid |
| out_res | output | 128 | Four-lane result |

## Verification
The bench builds the unit with its default parameters: 32-bit lanes with 16 fraction bits. It sweeps every one of the 16 opcode codes against all 64 ordered pairs drawn from eight lane values. Those values include ±1.0, ±1.5, the most positive and most negative words and the smallest positive step, which brings within reach:

- truncation of negative products;
- wrap of sums and products;
- signed compare at the extremes;
- equality for the set-on-compare operations.

Because issue is back-to-back with idle gaps at irregular points, the three-cycle valid alignment is also checked both under full occupancy and across bubbles.

// File: rtl/vau_pkg.sv
// Package: shared opcode encoding and lane count for the vector unit.
// Assumes four lanes per vector; opcode values are fixed by the instruction
// decoder upstream and must not be reordered.
package vau_pkg;
    localparam int NUM_LANES = 4;

    typedef enum logic [3:0] {
        OP_MOV = 4'd0,
        OP_MUL = 4'd1,
        OP_ADD = 4'd2,
        OP_MAD = 4'd3,
        OP_DP3 = 4'd4,
        OP_DP4 = 4'd5,
        OP_MIN = 4'd6,
        OP_MAX = 4'd7,
        OP_SLT = 4'd8,
        OP_SGE = 4'd9
    } vau_op_e;
endpackage

// File: rtl/vau_prod_stage.sv
// Stage 1: registers the instruction and forms one truncated fixed-point
// product per lane (A times B). Assumes operands are already swizzled/negated.
module vau_prod_stage
    import vau_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int FRAC_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [3:0]                    in_op,
    input  logic [NUM_LANES*LANE_W-1:0]   in_a,
    input  logic [NUM_LANES*LANE_W-1:0]   in_b,
    input  logic [NUM_LANES*LANE_W-1:0]   in_c,
    output logic                          s1_valid,
    output logic [3:0]                    s1_op,
    output logic [NUM_LANES*LANE_W-1:0]   s1_a,
    output logic [NUM_LANES*LANE_W-1:0]   s1_b,
    output logic [NUM_LANES*LANE_W-1:0]   s1_c,
    output logic [NUM_LANES*LANE_W-1:0]   s1_prod
);
    localparam int VEC_W  = NUM_LANES * LANE_W;
    localparam int FULL_W = 2 * LANE_W;

    logic [VEC_W-1:0] prod_d;

    // One full-width signed multiplier per lane, truncated back to the lane format.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane_mul
        logic signed [FULL_W-1:0] full;
        assign full = FULL_W'($signed(in_a[g*LANE_W +: LANE_W]))
                    * FULL_W'($signed(in_b[g*LANE_W +: LANE_W]));
        assign prod_d[g*LANE_W +: LANE_W] = LANE_W'(full >>> FRAC_W);
    end

    // Pipeline register for the valid bit; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= in_valid;
    end

    // Pipeline register for the instruction fields and the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op   <= '0;
            s1_a    <= '0;
            s1_b    <= '0;
            s1_c    <= '0;
            s1_prod <= '0;
        end else begin
            s1_op   <= in_op;
            s1_a    <= in_a;
            s1_b    <= in_b;
            s1_c    <= in_c;
            s1_prod <= prod_d;
        end
    end
endmodule

// File: rtl/vau_lane_stage.sv
// Stage 2: selects each lane's result by opcode and forms dot-product sums.
// Assumes stage 1 provides truncated per-lane products. Sums wrap.
module vau_lane_stage
    import vau_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int FRAC_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s1_valid,
    input  logic [3:0]                    s1_op,
    input  logic [NUM_LANES*LANE_W-1:0]   s1_a,
    input  logic [NUM_LANES*LANE_W-1:0]   s1_b,
    input  logic [NUM_LANES*LANE_W-1:0]   s1_c,
    input  logic [NUM_LANES*LANE_W-1:0]   s1_prod,
    output logic                          s2_valid,
    output logic [3:0]                    s2_op,
    output logic [NUM_LANES*LANE_W-1:0]   s2_res
);
    localparam int VEC_W = NUM_LANES * LANE_W;
    localparam logic [LANE_W-1:0] FIX_ONE = LANE_W'(1) << FRAC_W;

    logic [LANE_W-1:0] dot3;
    logic [LANE_W-1:0] dot4;
    logic [VEC_W-1:0]  res_d;

    // Reduction sums: all lanes but the last for DP3, every lane for DP4.
    always_comb begin
        dot3 = '0;
        for (int i = 0; i < NUM_LANES - 1; i++) dot3 = dot3 + s1_prod[i*LANE_W +: LANE_W];
        dot4 = dot3 + s1_prod[(NUM_LANES-1)*LANE_W +: LANE_W];
    end

    // Per-lane opcode selection; dot products are broadcast to every lane.
    always_comb begin
        res_d = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            logic [LANE_W-1:0] la, lb, lc, lp, r;
            logic              lt;
            la = s1_a[i*LANE_W +: LANE_W];
            lb = s1_b[i*LANE_W +: LANE_W];
            lc = s1_c[i*LANE_W +: LANE_W];
            lp = s1_prod[i*LANE_W +: LANE_W];
            lt = $signed(la) < $signed(lb);
            case (s1_op)
                OP_MOV:  r = la;
                OP_MUL:  r = lp;
                OP_ADD:  r = la + lb;
                OP_MAD:  r = lp + lc;
                OP_DP3:  r = dot3;
                OP_DP4:  r = dot4;
                OP_MIN:  r = lt ? la : lb;
                OP_MAX:  r = lt ? lb : la;
                OP_SLT:  r = lt ? FIX_ONE : '0;
                OP_SGE:  r = lt ? '0 : FIX_ONE;
                default: r = '0;
            endcase
            res_d[i*LANE_W +: LANE_W] = r;
        end
    end

    // Pipeline register for valid, opcode and the selected result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_op    <= '0;
            s2_res   <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_op    <= s1_op;
            s2_res   <= res_d;
        end
    end

    // R7: a min/max lane never produces a value outside its two operands.
    a_r7_minmax_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (s1_op == OP_MIN || s1_op == OP_MAX))
        |=> (s2_res[0 +: LANE_W] == $past(s1_a[0 +: LANE_W])
          || s2_res[0 +: LANE_W] == $past(s1_b[0 +: LANE_W])));
endmodule

// File: rtl/vau_out_stage.sv
// Stage 3: output register of the unit. Assumes stage 2 has already made
// the final lane values; this stage only aligns them to the fixed latency.
module vau_out_stage
    import vau_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int FRAC_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s2_valid,
    input  logic [3:0]                    s2_op,
    input  logic [NUM_LANES*LANE_W-1:0]   s2_res,
    output logic                          out_valid,
    output logic [NUM_LANES*LANE_W-1:0]   out_res
);
    localparam logic [LANE_W-1:0] FIX_ONE = LANE_W'(1) << FRAC_W;

    logic [3:0] op_q;

    // Output register; reset gives a quiet, zeroed output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            op_q      <= '0;
            out_res   <= '0;
        end else begin
            out_valid <= s2_valid;
            op_q      <= s2_op;
            out_res   <= s2_res;
        end
    end

    // R5/R6: a dot-product result is identical in every lane.
    a_r6_dot_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (op_q == OP_DP3 || op_q == OP_DP4))
        |-> (out_res[0 +: LANE_W] == out_res[LANE_W +: LANE_W]
          && out_res[0 +: LANE_W] == out_res[2*LANE_W +: LANE_W]
          && out_res[0 +: LANE_W] == out_res[3*LANE_W +: LANE_W]));

    // R8: set-on-compare lanes are exactly 0 or 1.0.
    a_r8_set_values: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (op_q == OP_SLT || op_q == OP_SGE))
        |-> ((out_res[0 +: LANE_W] == '0 || out_res[0 +: LANE_W] == FIX_ONE)
          && (out_res[3*LANE_W +: LANE_W] == '0 || out_res[3*LANE_W +: LANE_W] == FIX_ONE)));

    // R9: codes beyond the defined set give an all-zero vector.
    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q > 4'd9) |-> (out_res == '0));
endmodule

// File: rtl/vau_core.sv
// Top: three-stage four-lane Q16.16 vector arithmetic unit. Accepts one
// instruction per cycle; every opcode completes after exactly three edges.
// Assumes sources are pre-swizzled and that masking is done by the consumer.
module vau_core
    import vau_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int FRAC_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [3:0]                    in_op,
    input  logic [NUM_LANES*LANE_W-1:0]   in_a,
    input  logic [NUM_LANES*LANE_W-1:0]   in_b,
    input  logic [NUM_LANES*LANE_W-1:0]   in_c,
    output logic                          out_valid,
    output logic [NUM_LANES*LANE_W-1:0]   out_res
);
    localparam int VEC_W = NUM_LANES * LANE_W;

    logic             s1_valid, s2_valid;
    logic [3:0]       s1_op, s2_op;
    logic [VEC_W-1:0] s1_a, s1_b, s1_c, s1_prod, s2_res;
    logic [1:0]       warm;

    vau_prod_stage #(.LANE_W(LANE_W), .FRAC_W(FRAC_W)) u_prod (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .s1_valid(s1_valid), .s1_op(s1_op), .s1_a(s1_a), .s1_b(s1_b),
        .s1_c(s1_c), .s1_prod(s1_prod)
    );

    vau_lane_stage #(.LANE_W(LANE_W), .FRAC_W(FRAC_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_op(s1_op),
        .s1_a(s1_a), .s1_b(s1_b), .s1_c(s1_c), .s1_prod(s1_prod),
        .s2_valid(s2_valid), .s2_op(s2_op), .s2_res(s2_res)
    );

    vau_out_stage #(.LANE_W(LANE_W), .FRAC_W(FRAC_W)) u_out (
        .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_op(s2_op),
        .s2_res(s2_res), .out_valid(out_valid), .out_res(out_res)
    );

    // Saturating count of edges since reset release, used by the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R10: nothing emerges in the first cycle after reset release.
    a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd0) |-> !out_valid);

    // R1: once the pipeline is full of post-reset history, valid is a 3-cycle delay.
    a_r1_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));
endmodule

// File: tb/sim_vau_core.sv
module sim_vau_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = '0;
    logic [127:0] in_a = '0, in_b = '0, in_c = '0;
    logic         out_valid;
    logic [127:0] out_res;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    logic         exp_v  [0:4095];
    logic [127:0] exp_r  [0:4095];
    logic [3:0]   exp_op [0:4095];

    always #10 clk = ~clk;

    vau_core u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_valid(out_valid), .out_res(out_res)
    );

    function automatic logic [31:0] pick(input int k);
        case (k % 8)
            0: pick = 32'h0000_0000;
            1: pick = 32'h0001_0000;
            2: pick = 32'hFFFF_0000;
            3: pick = 32'h0001_8000;
            4: pick = 32'hFFFE_8000;
            5: pick = 32'h7FFF_FFFF;
            6: pick = 32'h8000_0000;
            default: pick = 32'h0000_0001;
        endcase
    endfunction

    function automatic logic [31:0] fmul(input logic [31:0] x, input logic [31:0] y);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        fmul = 32'(p >>> 16);
    endfunction

    function automatic logic [127:0] model(input logic [3:0] op, input logic [127:0] a,
                                           input logic [127:0] b, input logic [127:0] c);
        logic [31:0] x, y, z, s3, s4, r;
        model = '0;
        s3 = fmul(a[31:0], b[31:0]) + fmul(a[63:32], b[63:32]) + fmul(a[95:64], b[95:64]);
        s4 = s3 + fmul(a[127:96], b[127:96]);
        for (int i = 0; i < 4; i++) begin
            x = a[i*32 +: 32]; y = b[i*32 +: 32]; z = c[i*32 +: 32];
            case (op)
                4'd0: r = x;
                4'd1: r = fmul(x, y);
                4'd2: r = x + y;
                4'd3: r = fmul(x, y) + z;
                4'd4: r = s3;
                4'd5: r = s4;
                4'd6: r = ($signed(x) < $signed(y)) ? x : y;
                4'd7: r = ($signed(x) > $signed(y)) ? x : y;
                4'd8: r = ($signed(x) < $signed(y)) ? 32'h0001_0000 : 32'h0;
                4'd9: r = ($signed(x) >= $signed(y)) ? 32'h0001_0000 : 32'h0;
                default: r = 32'h0;
            endcase
            model[i*32 +: 32] = r;
        end
    endfunction

    function automatic string tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd2: tag = "R2";
            4'd1:       tag = "R3";
            4'd3:       tag = "R4";
            4'd4:       tag = "R5";
            4'd5:       tag = "R6";
            4'd6, 4'd7: tag = "R7";
            4'd8, 4'd9: tag = "R8";
            default:    tag = "R9";
        endcase
    endfunction

    // Check the outputs due this cycle, then drive the next instruction.
    task automatic step(input logic v, input logic [3:0] op, input logic [127:0] a,
                        input logic [127:0] b, input logic [127:0] c);
        @(negedge clk);
        if (cyc >= 3) begin
            checks++;
            if (out_valid !== exp_v[cyc-3]) begin
                bad++;
                $display("FAIL R1 cycle %0d out_valid=%b expected %b", cyc, out_valid, exp_v[cyc-3]);
            end
            if (exp_v[cyc-3]) begin
                checks++;
                if (out_res !== exp_r[cyc-3]) begin
                    bad++;
                    $display("FAIL %s op=%0d out_res=%h expected %h", tag(exp_op[cyc-3]),
                             exp_op[cyc-3], out_res, exp_r[cyc-3]);
                end
            end
        end else begin
            checks++;
            if (out_valid !== 1'b0) begin
                bad++;
                $display("FAIL R10 early out_valid=%b expected 0", out_valid);
            end
        end
        rst_n = 1'b1;
        in_valid = v; in_op = op; in_a = a; in_b = b; in_c = c;
        exp_v[cyc] = v;
        exp_op[cyc] = op;
        exp_r[cyc] = model(op, a, b, c);
        cyc++;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks + 1, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4096; k++) exp_v[k] = 1'b0;
        // Reset with garbage valid instructions present: they must be flushed (R10).
        in_valid = 1'b1; in_op = 4'd2; in_a = {4{32'h1234_5678}}; in_b = in_a;
        repeat (5) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_res !== '0) begin
            bad++;
            $display("FAIL R10 reset out_valid=%b out_res=%h expected 0 and 0", out_valid, out_res);
        end
        // Sweep every code against all ordered value pairs, with irregular bubbles.
        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    step(1'b1, 4'(op),
                         {pick(i+3), pick(i+j), pick(j), pick(i)},
                         {pick(j+5), pick(i+1), pick(i), pick(j)},
                         {pick(i^j), pick(j+2), pick(7-i), pick(i+j+1)});
                    if (((i*8 + j + op) % 7) == 6) step(1'b0, 4'd0, '0, '0, '0);
                end
            end
        end
        // R5: xyz equal, w differs widely; both must match (w ignored).
        step(1'b1, 4'd4, {32'h7FFF_FFFF, 32'h0002_0000, 32'h0001_8000, 32'hFFFF_0000},
                         {32'h7FFF_FFFF, 32'h0001_0000, 32'hFFFE_8000, 32'h0003_0000}, '0);
        step(1'b1, 4'd4, {32'h0000_0000, 32'h0002_0000, 32'h0001_8000, 32'hFFFF_0000},
                         {32'h8000_0000, 32'h0001_0000, 32'hFFFE_8000, 32'h0003_0000}, '0);
        repeat (5) step(1'b0, 4'd0, '0, '0, '0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule